// File: doc/BRIEF.md
# Interrupt Status and Node Router

This block gathers fifteen event sources of a capture/compare and PWM peripheral into one status word. Software can read the word but cannot write it directly. Bits are set either by a hardware strobe or by writing ones to a set port, and are cleared only by writing ones to a clear port. Every set event of an enabled source becomes an interrupt request. A two-bit selector per source steers that request to one of four shared interrupt lines. Each line emits a one-cycle pulse when its routed request rises.

Hardware strobes drive bits 0 to 13. In ascending order these are: rise then fall for capture channels 0, 1 and 2; timer A one-match and period-match; timer B compare-match and period-match; trap flag; trap state; correct Hall pattern; and wrong Hall pattern at bit 13. Bit 14 is the idle flag. When idle arming is enabled, the idle flag is set on the same clock edge as the wrong-Hall bit. It stays set until software clears it. While it is set, `idle_force_o` tells the modulation logic to drop its pattern and drive its outputs passive. A small two-state machine holds the idle flag. In state IDLE_RUN it moves to IDLE_FORCE on an arm event, which is a wrong-Hall set with arming enabled or a software set of bit 14. In IDLE_FORCE it returns to IDLE_RUN on a software clear of bit 14, but only in a cycle without an arm event.

Top module: `irq_status_router`

## Requirements
- R1: After reset the status word is zero, every interrupt line is low and `idle_force_o` is low.
- R2: A read at address 0 returns the status word in bits 14..0 with bit 15 at 0. Reads at address 1 (set port), address 2 (clear port) and address 3 return 0.
- R3: A write at address 0 leaves the status word unchanged.
- R4: A write at address 1 sets every status bit whose data bit is 1 on the next edge. Data bits at 0 have no effect.
- R5: A write at address 2 clears every status bit whose data bit is 1 on the next edge. Data bits at 0 have no effect.
- R6: A strobe on `hw_evt_i[i]` sets status bit i on the next edge. If a software clear of the same bit arrives in the same cycle, the set wins.
- R7: A set event from hardware or from the set port, on a source whose `src_en_i` bit is 1, raises a request. A disabled source still sets its status bit but raises no request.
- R8: Source s is routed to line `node_sel_i[2s+1:2s]`. Requests on one line are ORed. A line pulses high for exactly one cycle, the cycle after its ORed request rises. It does not pulse again while the request stays high.
- R9: With `idle_en_i` at 1, a wrong-Hall set (bit 13) also sets the idle flag (bit 14) on the same edge. With `idle_en_i` at 0 it does not.
- R10: `idle_force_o` equals the idle flag. The flag holds until a clear of bit 14. A clear that coincides with an arm event loses, and a set-port write to bit 14 also arms the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_evt_i | input | 14 | Hardware event strobes for status bits 0..13 |
| bus_addr_i | input | 2 | Register address: 0 status, 1 set port, 2 clear port |
| bus_wdata_i | input | 16 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| src_en_i | input | 15 | Per-source interrupt enable |
| node_sel_i | input | 30 | Two-bit line selector per source |
| idle_en_i | input | 1 | Enables arming of the idle flag by wrong-Hall events |
| irq_o | output | 4 | Interrupt line pulses |
| idle_force_o | output | 1 | Idle action request to modulation logic |

## Verification
A status flop that holds a wrong value shows on the very next read of address 0, because the read path is combinational. A lost or extra set event shows one cycle after the strobe, as a missing or extra pulse on the selected line. If the idle state machine sits in the wrong state, `idle_force_o` shows it in the cycle after the edge that moved it there, and it stays wrong until the next bit-14 clear. A stuck edge-detect flop shows up as a double pulse or as a pulse missing after a gap in requests.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_SET    = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CLEAR  = 2'd2;

    // idle flag holder states
    typedef enum logic [0:0] {
        IDLE_RUN   = 1'b0,
        IDLE_FORCE = 1'b1
    } idle_state_e;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_rt_pkg::*;
#(
    parameter int SRC_N  = 15,
    parameter int DATA_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_N-1:0]  status,
    output logic [SRC_N-1:0]  set_mask,
    output logic [SRC_N-1:0]  clr_mask,
    output logic [DATA_W-1:0] rdata
);

    // data bits above the source field carry no meaning
    logic unused_hi_bits;
    assign unused_hi_bits = ^wdata[DATA_W-1:SRC_N];

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (wr_en) begin
            if (addr == ADR_SET) begin
                set_mask = wdata[SRC_N-1:0];
            end else if (addr == ADR_CLEAR) begin
                clr_mask = wdata[SRC_N-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADR_STATUS) begin
            rdata[SRC_N-1:0] = status;
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int BIT_N = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BIT_N-1:0] hw_evt,
    input  logic [BIT_N-1:0] sw_set,
    input  logic [BIT_N-1:0] sw_clr,
    output logic [BIT_N-1:0] set_evt,
    output logic [BIT_N-1:0] status
);

    logic [BIT_N-1:0] bits_q;
    logic [BIT_N-1:0] bits_d;

    genvar g;
    generate
        for (g = 0; g < BIT_N; g++) begin : g_bit
            assign set_evt[g] = hw_evt[g] | sw_set[g];
            // a set in the same cycle overrides a clear
            assign bits_d[g]  = set_evt[g] ? 1'b1 :
                                sw_clr[g]  ? 1'b0 : bits_q[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign status = bits_q;

endmodule

// File: rtl/irq_idle_fsm.sv
module irq_idle_fsm
    import irq_rt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_en,
    input  logic whe_set,
    input  logic sw_set,
    input  logic sw_clr,
    output logic arm,
    output logic idle_flag
);

    idle_state_e state_q;
    idle_state_e state_d;

    assign arm = sw_set | (idle_en & whe_set);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_RUN: begin
                if (arm) state_d = IDLE_FORCE;
            end
            IDLE_FORCE: begin
                if (sw_clr && !arm) state_d = IDLE_RUN;
            end
        endcase
    end

    always_comb begin
        idle_flag = (state_q == IDLE_FORCE);
    end

endmodule

// File: rtl/irq_node_router.sv
module irq_node_router #(
    parameter int SRC_N  = 15,
    parameter int NODE_N = 4,
    parameter int PTR_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SRC_N-1:0]       req,
    input  logic [SRC_N*PTR_W-1:0] sel,
    output logic [NODE_N-1:0]      irq
);

    logic [NODE_N-1:0][SRC_N-1:0] hit;
    logic [NODE_N-1:0]            lvl;
    logic [NODE_N-1:0]            lvl_q;
    logic [NODE_N-1:0]            irq_q;

    genvar n, s;
    generate
        for (n = 0; n < NODE_N; n++) begin : g_node
            for (s = 0; s < SRC_N; s++) begin : g_src
                assign hit[n][s] = req[s] &&
                                   (sel[s*PTR_W +: PTR_W] == PTR_W'(n));
            end
            assign lvl[n] = |hit[n];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            irq_q <= '0;
        end else begin
            lvl_q <= lvl;
            irq_q <= lvl & ~lvl_q;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/irq_status_router.sv
module irq_status_router
    import irq_rt_pkg::*;
#(
    parameter int SRC_N  = 15,
    parameter int DATA_W = 16,
    parameter int NODE_N = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SRC_N-2:0]                 hw_evt_i,
    input  logic [ADDR_W-1:0]                bus_addr_i,
    input  logic [DATA_W-1:0]                bus_wdata_i,
    input  logic                             bus_wr_i,
    output logic [DATA_W-1:0]                bus_rdata_o,
    input  logic [SRC_N-1:0]                 src_en_i,
    input  logic [SRC_N*$clog2(NODE_N)-1:0]  node_sel_i,
    input  logic                             idle_en_i,
    output logic [NODE_N-1:0]                irq_o,
    output logic                             idle_force_o
);

    localparam int PTR_W    = $clog2(NODE_N);
    localparam int LOW_N    = SRC_N - 1;
    localparam int IDLE_BIT = SRC_N - 1;
    localparam int WHE_BIT  = SRC_N - 2;

    logic [SRC_N-1:0] set_mask;
    logic [SRC_N-1:0] clr_mask;
    logic [SRC_N-1:0] status_w;
    logic [LOW_N-1:0] low_set_evt;
    logic [LOW_N-1:0] low_status;
    logic             idle_arm;
    logic             idle_flag;
    logic [SRC_N-1:0] src_req;

    irq_bus_decode #(
        .SRC_N  (SRC_N),
        .DATA_W (DATA_W)
    ) u_dec (
        .wr_en    (bus_wr_i),
        .addr     (bus_addr_i),
        .wdata    (bus_wdata_i),
        .status   (status_w),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .rdata    (bus_rdata_o)
    );

    irq_status_bank #(
        .BIT_N (LOW_N)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_evt  (hw_evt_i),
        .sw_set  (set_mask[LOW_N-1:0]),
        .sw_clr  (clr_mask[LOW_N-1:0]),
        .set_evt (low_set_evt),
        .status  (low_status)
    );

    irq_idle_fsm u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_en   (idle_en_i),
        .whe_set   (low_set_evt[WHE_BIT]),
        .sw_set    (set_mask[IDLE_BIT]),
        .sw_clr    (clr_mask[IDLE_BIT]),
        .arm       (idle_arm),
        .idle_flag (idle_flag)
    );

    assign src_req  = {idle_arm, low_set_evt} & src_en_i;
    assign status_w = {idle_flag, low_status};

    irq_node_router #(
        .SRC_N  (SRC_N),
        .NODE_N (NODE_N),
        .PTR_W  (PTR_W)
    ) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (src_req),
        .sel   (node_sel_i),
        .irq   (irq_o)
    );

    assign idle_force_o = idle_flag;

endmodule

// File: rtl/irq_status_router_chk.sv
module irq_status_router_chk
    import irq_rt_pkg::*;
#(
    parameter int SRC_N  = 15,
    parameter int DATA_W = 16,
    parameter int NODE_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-2:0]  hw_evt_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              bus_wr_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              idle_en_i,
    input logic [NODE_N-1:0] irq_o,
    input logic              idle_force_o,
    input logic [SRC_N-1:0]  status_w
);

    AST_RD_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_o >> SRC_N) == '0); // R2

    AST_RD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == ADR_STATUS) |-> (bus_rdata_o[SRC_N-1:0] == status_w)); // R2

    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADR_STATUS && hw_evt_i == '0)
        |=> (status_w == $past(status_w))); // R3

    AST_SET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADR_SET)
        |=> ((status_w & $past(bus_wdata_i[SRC_N-1:0])) == $past(bus_wdata_i[SRC_N-1:0]))); // R4

    AST_CLEAR_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADR_CLEAR && hw_evt_i == '0)
        |=> ((status_w & $past(bus_wdata_i[SRC_N-1:0])) == '0)); // R5

    AST_HW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt_i != '0)
        |=> ((status_w[SRC_N-2:0] & $past(hw_evt_i)) == $past(hw_evt_i))); // R6

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |=> ((irq_o & $past(irq_o)) == '0)); // R8

    AST_IDLE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_en_i && hw_evt_i[SRC_N-2]) |=> (status_w[SRC_N-1] && idle_force_o)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_force_o && !(bus_wr_i && bus_addr_i == ADR_CLEAR && bus_wdata_i[SRC_N-1]))
        |=> idle_force_o); // R10

endmodule

bind irq_status_router irq_status_router_chk #(
    .SRC_N  (SRC_N),
    .DATA_W (DATA_W),
    .NODE_N (NODE_N)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_evt_i     (hw_evt_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_wr_i     (bus_wr_i),
    .bus_rdata_o  (bus_rdata_o),
    .idle_en_i    (idle_en_i),
    .irq_o        (irq_o),
    .idle_force_o (idle_force_o),
    .status_w     (status_w)
);

// File: tb/irq_status_router_test.sv
`timescale 1ns/1ps
module irq_status_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] hw = '0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic [15:0] rdata;
    logic [14:0] en = '1;
    logic [29:0] sel = '0;
    logic        idle_en = 1'b0;
    logic [3:0]  irq;
    logic        idle_force;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          cyc;
        string       tag;
        bit          is_rd;
        logic [15:0] rd;
        logic [3:0]  irq;
        logic        idle;
    } item_t;

    item_t sbq[$];

    logic [14:0] m_stat = '0;
    logic [3:0]  m_prev = '0;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    irq_status_router uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_evt_i     (hw),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_wr_i     (wr),
        .bus_rdata_o  (rdata),
        .src_en_i     (en),
        .node_sel_i   (sel),
        .idle_en_i    (idle_en),
        .irq_o        (irq),
        .idle_force_o (idle_force)
    );

    // driver: applies one cycle of stimulus, pushes the expected items
    task automatic step(input string tag, input logic [13:0] h, input logic w,
                        input logic [1:0] a, input logic [15:0] d);
        item_t it;
        logic [14:0] setm;
        logic [14:0] clrm;
        logic [3:0]  lvl;
        @(negedge clk);
        hw = h; wr = w; addr = a; wdata = d;
        it.cyc = cyc; it.tag = tag; it.is_rd = 1'b1;
        it.rd = (a == 2'd0) ? {1'b0, m_stat} : 16'h0000;
        it.irq = '0; it.idle = 1'b0;
        sbq.push_back(it);
        setm = {1'b0, h} | ((w && a == 2'd1) ? d[14:0] : 15'h0);
        if ((idle_en && setm[13]) || (w && a == 2'd1 && d[14])) setm[14] = 1'b1;
        clrm = (w && a == 2'd2) ? d[14:0] : 15'h0;
        m_stat = (m_stat & ~clrm) | setm;
        lvl = '0;
        for (int s = 0; s < 15; s++) begin
            if (setm[s] && en[s]) lvl[sel[2*s +: 2]] = 1'b1;
        end
        it.cyc = cyc + 1; it.is_rd = 1'b0;
        it.irq = lvl & ~m_prev; it.idle = m_stat[14];
        sbq.push_back(it);
        m_prev = lvl;
        @(posedge clk); #1;
        hw = '0; wr = 1'b0;
    endtask

    // monitor: pops and compares the items due in the current cycle
    initial begin
        item_t it;
        forever begin
            @(negedge clk); #1;
            while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
                it = sbq.pop_front();
                n_chk++;
                if (it.cyc != cyc) begin
                    n_bad++;
                    $display("FAIL %s stale item: actual cycle=%0d expected cycle=%0d",
                             it.tag, cyc, it.cyc);
                end else if (it.is_rd) begin
                    if (rdata !== it.rd) begin
                        n_bad++;
                        $display("FAIL %s rdata: actual=%h expected=%h", it.tag, rdata, it.rd);
                    end
                end else if (irq !== it.irq || idle_force !== it.idle) begin
                    n_bad++;
                    $display("FAIL %s irq/idle: actual=%b/%b expected=%b/%b",
                             it.tag, irq, idle_force, it.irq, it.idle);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 15; s++) sel[2*s +: 2] = 2'(s % 4);
        repeat (3) @(negedge clk);
        n_chk++;
        if (irq !== 4'h0 || idle_force !== 1'b0 || rdata !== 16'h0) begin   // R1 in reset
            n_bad++;
            $display("FAIL R1 reset: actual=%b/%b/%h expected=0/0/0", irq, idle_force, rdata);
        end
        rst_n = 1'b1;
        step("R1", 14'h0, 1'b0, 2'd0, 16'h0);
        // R4 set port, sources 0 and 2 go to lines 0 and 2 (R7)
        step("R4", 14'h0, 1'b1, 2'd1, 16'h0005);
        step("R2", 14'h0, 1'b0, 2'd0, 16'h0);
        step("R2", 14'h0, 1'b0, 2'd1, 16'h0);
        step("R2", 14'h0, 1'b0, 2'd2, 16'h0);
        step("R2", 14'h0, 1'b0, 2'd3, 16'h0);
        // R3 write to status address ignored
        step("R3", 14'h0, 1'b1, 2'd0, 16'hFFFF);
        step("R3", 14'h0, 1'b0, 2'd0, 16'h0);
        // R5 clear bit 0 only
        step("R5", 14'h0, 1'b1, 2'd2, 16'h0001);
        step("R5", 14'h0, 1'b0, 2'd0, 16'h0);
        // R6 hardware strobes, both on line 1 (R8 OR)
        step("R6", 14'h0022, 1'b0, 2'd0, 16'h0);
        step("R6", 14'h0, 1'b0, 2'd0, 16'h0);
        // R6 set beats a simultaneous clear
        step("R6", 14'h0008, 1'b1, 2'd2, 16'h0008);
        step("R6", 14'h0, 1'b0, 2'd0, 16'h0);
        // R8 held request pulses once, two sources same line
        step("R8", 14'h0011, 1'b0, 2'd0, 16'h0);
        step("R8", 14'h0011, 1'b0, 2'd0, 16'h0);
        step("R8", 14'h0, 1'b0, 2'd0, 16'h0);
        step("R8", 14'h0010, 1'b0, 2'd0, 16'h0);
        // R7 disabled source sets status but no pulse
        en[6] = 1'b0;
        step("R7", 14'h0040, 1'b0, 2'd0, 16'h0);
        step("R7", 14'h0, 1'b0, 2'd0, 16'h0);
        en[6] = 1'b1;
        // R8 reroute source 7 to line 0
        sel[14 +: 2] = 2'd0;
        step("R8", 14'h0080, 1'b0, 2'd0, 16'h0);
        step("R8", 14'h0, 1'b0, 2'd0, 16'h0);
        // R5 clear all
        step("R5", 14'h0, 1'b1, 2'd2, 16'h7FFF);
        step("R5", 14'h0, 1'b0, 2'd0, 16'h0);
        // R9 wrong-Hall without arming
        step("R9", 14'h2000, 1'b0, 2'd0, 16'h0);
        step("R9", 14'h0, 1'b0, 2'd0, 16'h0);
        idle_en = 1'b1;
        step("R9", 14'h2000, 1'b0, 2'd0, 16'h0);
        step("R9", 14'h0, 1'b0, 2'd0, 16'h0);
        // R10 hold, clear of bit 13 alone, clear losing to arm, real clear
        step("R10", 14'h0, 1'b1, 2'd2, 16'h2000);
        step("R10", 14'h0, 1'b0, 2'd0, 16'h0);
        step("R10", 14'h2000, 1'b1, 2'd2, 16'h4000);
        step("R10", 14'h0, 1'b0, 2'd0, 16'h0);
        step("R10", 14'h0, 1'b1, 2'd2, 16'h4000);
        step("R10", 14'h0, 1'b0, 2'd0, 16'h0);
        // R10 arming through the set port
        idle_en = 1'b0;
        step("R10", 14'h0, 1'b1, 2'd1, 16'h4000);
        step("R10", 14'h0, 1'b0, 2'd0, 16'h0);
        step("R10", 14'h0, 1'b1, 2'd2, 16'h7FFF);
        step("R1", 14'h0, 1'b0, 2'd0, 16'h0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule